// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer governed by a single 16-bit control word. Software writes the word to set a reload count and to start or stop the countdown. Once a stored word has its enable bit set, each further write must carry a key that is the bitwise inverse of the stored key. A write with any other key is dropped without effect. This makes it unlikely that a runaway program can feed or disable the watchdog by accident.

The countdown advances only on cycles where a slow tick-enable input is high, nominally around 760 Hz. When the count first runs out, the block raises a non-maskable interrupt (NMI) and starts a fixed grace period of 10 ticks. If that grace period also runs out before an accepted write, the block pulses a reset request and stops. An accepted write clears the NMI and the recorded timeout.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `nmi_o` and `rst_req_o` are low, the countdown is stopped so ticks cause no timeout, and the stored control word is zero, which means disabled with key zero.
- R2: The control word has the reload count in bits [7:0], the run command in bit 8 and the key in bits [15:9]. Bit 8 of the stored word is the enable that arms the key check.
- R3: While the stored enable bit is 0, every write is accepted whatever key it carries.
- R4: While the stored enable bit is 1, a write is accepted only if its key equals the bitwise inverse of the stored 7-bit key. Any other write changes nothing: not the stored word, not the count, not the NMI.
- R5: An accepted write with the run bit set loads the count field. The first timeout then occurs on exactly that many ticks, and a count field of 0 means 256 ticks. `nmi_o` is high in the cycle after the tick that ends the count.
- R6: An accepted write with the run bit clear stops the countdown, so no timeout follows any number of ticks.
- R7: The first timeout sets `nmi_o` and reloads the counter with 10 ticks, and the countdown keeps running.
- R8: A timeout that comes while a timeout is already recorded drives `rst_req_o` high for exactly one cycle, in the cycle after the 10th grace tick, and then stops the countdown.
- R9: An accepted write clears `nmi_o` and the recorded timeout. `nmi_o` stays high until such a write arrives.
- R10: The counter changes only on cycles with `tick` high, so a cycle with `tick` low never produces a timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word: count [7:0], run [8], key [15:9] |
| tick | input | 1 | Countdown enable, one tick per high cycle |
| nmi_o | output | 1 | Non-maskable interrupt, held until an accepted write |
| rst_req_o | output | 1 | Reset request, one-cycle pulse |

## Verification
The assertions take it for granted that `tick` and `wr_en` are synchronous to `clk`, with `tick` a one-cycle strobe per count step. They also assume that a write and a tick in the same cycle resolve with the write winning. The bench drives every input on the falling edge and raises `tick` for a single cycle at a time. It tracks the stored word itself, so that each key it presents is deliberately either the inverse or a wrong value. It overlaps writes with expiry only where a requirement calls for it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned WDG_CNT_W = 8;
  localparam int unsigned WDG_KEY_W = 7;
  localparam int unsigned WDG_GRACE = 10;

  typedef enum logic {
    STG_ARMED = 1'b0,
    STG_HIT   = 1'b1
  } wdg_stage_e;
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate #(
  parameter int unsigned CNT_W = wdg_pkg::WDG_CNT_W,
  parameter int unsigned KEY_W = wdg_pkg::WDG_KEY_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CNT_W+KEY_W:0]   wr_data,
  output logic                   accept_o
);
  localparam int unsigned WORD_W = CNT_W + KEY_W + 1;
  localparam int unsigned EN_BIT = CNT_W;

  logic [WORD_W-1:0] ctrl_q;

  function automatic logic [KEY_W-1:0] key_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:EN_BIT+1];
  endfunction

  function automatic logic en_of(input logic [WORD_W-1:0] w);
    return w[EN_BIT];
  endfunction

  // R3/R4: key must be the inverse of the stored key when armed
  function automatic logic key_ok(input logic [WORD_W-1:0] stored,
                                  input logic [WORD_W-1:0] incoming);
    return !en_of(stored) || (key_of(incoming) == ~key_of(stored));
  endfunction

  assign accept_o = wr_en && key_ok(ctrl_q, wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (accept_o) begin
      ctrl_q <= wr_data;
    end
  end

  p_reject_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept_o) |=> $stable(ctrl_q));

  p_open_accepts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !en_of(ctrl_q)) |-> accept_o);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CNT_W = wdg_pkg::WDG_CNT_W,
  parameter int unsigned GRACE = wdg_pkg::WDG_GRACE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             load_run,
  input  logic             tick,
  input  logic             hit_seen,
  output logic             expire_o
);
  localparam int unsigned CW = CNT_W + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << CNT_W;
  localparam logic [CW-1:0] GRACE_V = CW'(GRACE);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  // R5: a zero count field stands for the full range
  function automatic logic [CW-1:0] reload_of(input logic [CNT_W-1:0] f);
    return (f == '0) ? FULL : {1'b0, f};
  endfunction

  assign expire_o = tick && run_q && !load && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= reload_of(load_cnt);
      run_q <= load_run;
    end else if (tick && run_q) begin
      if (cnt_q == CW'(1)) begin
        if (hit_seen) begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end else begin
          cnt_q <= GRACE_V;
        end
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  p_cnt_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0 && cnt_q <= FULL));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> ($stable(cnt_q) && $stable(run_q)));

  p_stop_after_reset_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && hit_seen) |=> !run_q);

  p_grace_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !hit_seen) |=> (run_q && cnt_q == GRACE_V));
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic expire,
  output logic hit_seen_o,
  output logic nmi_o,
  output logic rst_req_o
);
  wdg_stage_e st_q;

  assign hit_seen_o = (st_q == STG_HIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= STG_ARMED;
      nmi_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else if (clear) begin
      st_q      <= STG_ARMED;
      nmi_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else if (expire) begin
      if (st_q == STG_ARMED) begin
        st_q  <= STG_HIT;
        nmi_o <= 1'b1;
      end else begin
        rst_req_o <= 1'b1;
      end
    end else begin
      rst_req_o <= 1'b0;
    end
  end

  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_rst_needs_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> nmi_o);

  p_nmi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o && !clear) |=> nmi_o);

  p_first_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !clear && st_q == STG_ARMED) |=> (nmi_o && !rst_req_o));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int unsigned CNT_W = wdg_pkg::WDG_CNT_W,
  parameter int unsigned KEY_W = wdg_pkg::WDG_KEY_W,
  parameter int unsigned GRACE = wdg_pkg::WDG_GRACE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CNT_W+KEY_W:0] wr_data,
  input  logic                 tick,
  output logic                 nmi_o,
  output logic                 rst_req_o
);
  logic wr_accept;
  logic expire_evt;
  logic hit_seen;

  wdg_key_gate #(.CNT_W(CNT_W), .KEY_W(KEY_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .accept_o (wr_accept)
  );

  wdg_counter #(.CNT_W(CNT_W), .GRACE(GRACE)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_accept),
    .load_cnt (wr_data[CNT_W-1:0]),
    .load_run (wr_data[CNT_W]),
    .tick     (tick),
    .hit_seen (hit_seen),
    .expire_o (expire_evt)
  );

  wdg_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (wr_accept),
    .expire     (expire_evt),
    .hit_seen_o (hit_seen),
    .nmi_o      (nmi_o),
    .rst_req_o  (rst_req_o)
  );

  p_no_expire_without_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |-> tick);

  p_write_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (!nmi_o && !rst_req_o));
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        nmi_o;
  logic        rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] stored = '0;

  localparam int NV = 5;
  localparam logic [7:0] VEC_CNT [NV] = '{8'd1, 8'd5, 8'd37, 8'd255, 8'd0};
  localparam int         VEC_EXP [NV] = '{1, 5, 37, 255, 256};

  always #10 clk = ~clk;

  keyed_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // word layout per R2: key [15:9], run [8], count [7:0]
  function automatic logic [15:0] mk(input logic [6:0] key, input logic run,
                                     input logic [7:0] cnt);
    return {key, run, cnt};
  endfunction

  function automatic logic [6:0] good_key();
    return stored[8] ? ~stored[15:9] : 7'h2A;
  endfunction

  task automatic wr(input logic [15:0] d, input bit accepted);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (accepted) stored = d;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    stored = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 nmi after reset", nmi_o, 1'b0);
    check("R1 rst_req after reset", rst_req_o, 1'b0);
    ticks(300);
    check("R1 stopped after reset", nmi_o, 1'b0);

    // vector table: count field -> ticks to first timeout (R2, R5, R9)
    for (int v = 0; v < NV; v++) begin
      wr(mk(good_key(), 1'b1, VEC_CNT[v]), 1'b1);
      check("R9 accepted write clears nmi", nmi_o, 1'b0);
      ticks(VEC_EXP[v] - 1);
      check("R5 no timeout before count", nmi_o, 1'b0);
      ticks(1);
      check("R5 timeout at count", nmi_o, 1'b1);
    end

    // grace stage R7 / R8
    ticks(9);
    check("R7 no reset inside grace", rst_req_o, 1'b0);
    check("R7 nmi held in grace", nmi_o, 1'b1);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R8 reset request after grace", rst_req_o, 1'b1);
    @(negedge clk);
    check("R8 reset request one cycle", rst_req_o, 1'b0);
    ticks(20);
    check("R8 stopped after reset request", rst_req_o, 1'b0);
    check("R9 nmi held without write", nmi_o, 1'b1);

    // key rejection R4
    wr(mk(stored[15:9], 1'b1, 8'd50), 1'b0);
    check("R4 wrong key leaves nmi", nmi_o, 1'b1);
    wr(mk(good_key(), 1'b1, 8'd3), 1'b1);
    check("R9 right key clears nmi", nmi_o, 1'b0);
    wr(mk(~good_key(), 1'b1, 8'd200), 1'b0);
    ticks(3);
    check("R4 wrong key did not reload", nmi_o, 1'b1);

    // R10: no ticks, no progress
    wr(mk(good_key(), 1'b1, 8'd2), 1'b1);
    repeat (50) @(negedge clk);
    check("R10 idle cycles no timeout", nmi_o, 1'b0);
    ticks(2);
    check("R10 ticks finish count", nmi_o, 1'b1);

    // R6: run bit clear stops, and stores enable 0
    wr(mk(good_key(), 1'b0, 8'd4), 1'b1);
    ticks(300);
    check("R6 stopped countdown", nmi_o, 1'b0);

    // R3: stored enable clear, any key accepted
    wr(mk(7'h55, 1'b1, 8'd2), 1'b1);
    ticks(2);
    check("R3 any key accepted when disabled", nmi_o, 1'b1);

    // R1: reset clears stored word (key 0x11 would be refused otherwise)
    do_reset();
    check("R1 nmi cleared by reset", nmi_o, 1'b0);
    wr(mk(7'h11, 1'b1, 8'd1), 1'b1);
    ticks(1);
    check("R1 control word cleared by reset", nmi_o, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule